// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

This block is an 8-bit up-counter that runs in one of two modes. In watchdog mode, an overflow produces a single-cycle pulse on an output pin, and the logic outside the block turns that pulse into a reset. In interval mode, an overflow sets a sticky flag, and that flag drives a level interrupt. A free-running 12-bit prescaler produces eight tick rates. A 3-bit select field in the control byte picks one of them, and each selected tick advances the counter by one.

Software writes the block over a 16-bit port. A write changes a register only when the upper byte of the port carries the key that belongs to that register, so a stray store cannot reload the counter or reprogramme the timer. Reads return one byte and need no key.

The sticky flag is handled by a three-state machine:
- **FLAG_IDLE**: the flag is clear. An interval-mode overflow moves the machine to FLAG_UP.
- **FLAG_UP**: the flag is set but has not yet been read. A read of the control byte moves the machine to FLAG_ARMED.
- **FLAG_ARMED**: the flag is set and has been read. A keyed control write with bit 7 at 0 moves the machine back to FLAG_IDLE. A fresh overflow moves it back to FLAG_UP.

Top module: `keyed_wdt`

## Requirements
- R1: The counter increments by one on each prescaler tick while the enable bit (control bit 5) is 1, and wraps from 0xFF to 0x00. While the enable bit is 0, the counter holds its value.
- R2: The prescaler is a 12-bit counter. Reset clears it, and it advances on every clock. The select code c (control bits 2:0) chooses a ratio from 1, 4, 16, 32, 64, 256, 1024 or 4096. A tick occurs on each cycle in which the low log2(ratio) bits of the prescaler are all ones; ratio 1 ticks on every cycle.
- R3: A write with wr_en=1, wr_wide=1, wr_sel=0 and upper byte 0x5A loads the lower byte into the counter. This load takes priority over an increment in the same cycle, and in that cycle no overflow occurs.
- R4: A write with wr_en=1, wr_wide=1, wr_sel=1 and upper byte 0xA5 loads the mode bit (bit 6), the enable bit (bit 5) and the select field (bits 2:0) from the lower byte.
- R5: The following writes change no register: a write with the wrong key, a write with wr_wide=0, and a write that carries the other register's key.
- R6: Writing 0 to the flag (control bit 7) clears it only if the control byte was read (rd_en=1, rd_sel=1) while the flag was 1, before that write. Writing 1 to the flag never changes it.
- R7: In watchdog mode (bit 6 = 1), an overflow raises ovf_pulse for exactly one cycle, in the same cycle that the counter reads 0x00. It does not set the flag.
- R8: In interval mode (bit 6 = 0), an overflow sets the flag. irq equals the flag while the mode bit is 0, and is 0 in watchdog mode.
- R9: rd_sel=0 reads the counter. rd_sel=1 reads {flag, mode, enable, 2'b11, select}. Bits 4:3 always read 11, whatever value was written to them.
- R10: After reset the counter reads 0x00, the control byte reads 0x18, and irq and ovf_pulse are 0.
- R11: If an interval overflow and a flag-clearing write occur in the same cycle, the flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | 1 for a 16-bit write, 0 for an 8-bit write |
| wr_sel | input | 1 | Write target: 0 = counter, 1 = control |
| wr_data | input | 16 | Key in bits 15:8, value in bits 7:0 |
| rd_en | input | 1 | Read strobe; arms the flag clear when rd_sel=1 |
| rd_sel | input | 1 | Read target: 0 = counter, 1 = control |
| rd_data | output | 8 | Byte selected by rd_sel |
| ovf_pulse | output | 1 | One-cycle pulse on a watchdog overflow |
| irq | output | 1 | Interval interrupt level |

## Verification
The hardest case to produce from the ports is an interval overflow that lands in exactly the same cycle as an armed flag-clearing write. The stimulus reaches it in a fixed sequence:
1. Arm the flag by reading it.
2. Load 0xFE into the counter with the fastest tick selected.
3. Wait one idle cycle.
4. Issue the clear write.

The slowest tap would otherwise need a million cycles to overflow. Each directed run therefore preloads 0xFF so that only the prescaler period has to elapse. A cycle-accurate model in the bench then tracks every port through a long random mix of keyed, mis-keyed and narrow writes.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    typedef enum logic [1:0] {
        FLAG_IDLE  = 2'd0,
        FLAG_UP    = 2'd1,
        FLAG_ARMED = 2'd2
    } flag_state_e;

    // log2 of the prescaler ratio for each select code
    function automatic int tap_shift(input int code);
        case (code)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            3:       return 5;
            4:       return 6;
            5:       return 8;
            6:       return 10;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int PRE_W = 12,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NTAP = 1 << SEL_W;

    logic [PRE_W-1:0] pre_q;
    logic [NTAP-1:0]  tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        localparam int SH = kwdt_pkg::tap_shift(g);
        if (SH == 0) begin : g_full
            assign tap[g] = 1'b1;
        end else begin : g_div
            assign tap[g] = &pre_q[SH-1:0];
        end
    end

    assign tick = tap[sel];
endmodule

// File: rtl/kwdt_keycheck.sv
module kwdt_keycheck #(
    parameter int              KEY_W   = 8,
    parameter int              DATA_W  = 8,
    parameter logic [KEY_W-1:0] KEY_CNT = 8'h5A,
    parameter logic [KEY_W-1:0] KEY_CTL = 8'hA5
) (
    input  logic                    wr_en,
    input  logic                    wr_wide,
    input  logic                    wr_sel,
    input  logic [KEY_W+DATA_W-1:0] wr_data,
    output logic                    ld_cnt,
    output logic                    ld_ctl,
    output logic [DATA_W-1:0]       wbyte
);
    logic [KEY_W-1:0] key;
    logic             wide_wr;

    assign key     = wr_data[KEY_W+DATA_W-1:DATA_W];
    assign wbyte   = wr_data[DATA_W-1:0];
    assign wide_wr = wr_en & wr_wide;
    assign ld_cnt  = wide_wr & ~wr_sel & (key == KEY_CNT);
    assign ld_ctl  = wide_wr &  wr_sel & (key == KEY_CTL);
endmodule

// File: rtl/kwdt_flag_fsm.sv
module kwdt_flag_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_set,
    input  logic rd_flag,
    input  logic clr_wr,
    output logic flag
);
    import kwdt_pkg::*;

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (ovf_set) state_d = FLAG_UP;
            end
            FLAG_UP: begin
                if (!ovf_set && rd_flag) state_d = FLAG_ARMED;
            end
            FLAG_ARMED: begin
                if (ovf_set)     state_d = FLAG_UP;
                else if (clr_wr) state_d = FLAG_IDLE;
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLAG_UP, FLAG_ARMED: flag = 1'b1;
            default:             flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int         CNT_W   = 8,
    parameter int         PRE_W   = 12,
    parameter int         SEL_W   = 3,
    parameter logic [7:0] KEY_CNT = 8'h5A,
    parameter logic [7:0] KEY_CTL = 8'hA5,
    parameter logic [1:0] RSVD    = 2'b11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_wide,
    input  logic               wr_sel,
    input  logic [2*CNT_W-1:0] wr_data,
    input  logic               rd_en,
    input  logic               rd_sel,
    output logic [CNT_W-1:0]   rd_data,
    output logic               ovf_pulse,
    output logic               irq
);
    localparam int             FLAG_B  = 7;
    localparam int             MODE_B  = 6;
    localparam int             EN_B    = 5;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             mode_q, en_q, pulse_q;
    logic [SEL_W-1:0] cks_q;
    logic             tick, inc, ovf_int, ovf_set;
    logic             ld_cnt, ld_ctl, flag;
    logic [CNT_W-1:0] wbyte;

    kwdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cks_q),
        .tick  (tick)
    );

    kwdt_keycheck #(.KEY_W(8), .DATA_W(CNT_W), .KEY_CNT(KEY_CNT), .KEY_CTL(KEY_CTL)) u_key (
        .wr_en   (wr_en),
        .wr_wide (wr_wide),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ld_cnt  (ld_cnt),
        .ld_ctl  (ld_ctl),
        .wbyte   (wbyte)
    );

    assign inc     = en_q & tick;
    assign ovf_int = inc & (cnt_q == CNT_MAX) & ~ld_cnt;
    assign ovf_set = ovf_int & ~mode_q;

    kwdt_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_set (ovf_set),
        .rd_flag (rd_en & rd_sel),
        .clr_wr  (ld_ctl & ~wbyte[FLAG_B]),
        .flag    (flag)
    );

    // counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (ld_cnt) cnt_q <= wbyte;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            en_q   <= 1'b0;
            cks_q  <= '0;
        end else if (ld_ctl) begin
            mode_q <= wbyte[MODE_B];
            en_q   <= wbyte[EN_B];
            cks_q  <= wbyte[SEL_W-1:0];
        end
    end

    // watchdog pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= ovf_int & mode_q;
    end

    assign ovf_pulse = pulse_q;
    assign irq       = flag & ~mode_q;
    assign rd_data   = rd_sel ? {flag, mode_q, en_q, RSVD, cks_q} : cnt_q;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter logic [7:0] KEY_CTL = 8'hA5,
    parameter logic [7:0] KEY_CNT = 8'h5A,
    parameter logic [1:0] RSVD    = 2'b11
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_wide,
    input logic        wr_sel,
    input logic [15:0] wr_data,
    input logic        rd_sel,
    input logic [7:0]  rd_data,
    input logic        ovf_pulse,
    input logic [7:0]  cnt_q,
    input logic        en_q,
    input logic        mode_q,
    input logic        flag
);
    // R7: pulse lasts a single cycle
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

    // R7: pulse coincides with the wrapped counter
    assert_pulse_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> cnt_q == 8'h00);

    // R7: watchdog overflow never raises the flag
    assert_no_flag_wd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> !$rose(flag));

    // R8: flag rises only from an interval wrap
    assert_flag_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (!$past(mode_q) && $past(cnt_q) == 8'hFF && $past(en_q)));

    // R1: disabled counter holds unless loaded
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !(wr_en && wr_wide && !wr_sel && wr_data[15:8] == KEY_CNT)) |=> $stable(cnt_q));

    // R6: flag falls only after a keyed write of 0
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(wr_en && wr_wide && wr_sel && wr_data[15:8] == KEY_CTL && !wr_data[7]));

    // R9: reserved bits read fixed
    assert_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> rd_data[4:3] == RSVD);
endmodule

bind keyed_wdt kwdt_checker #(.KEY_CTL(KEY_CTL), .KEY_CNT(KEY_CNT), .RSVD(RSVD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_wide   (wr_wide),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .ovf_pulse (ovf_pulse),
    .cnt_q     (cnt_q),
    .en_q      (en_q),
    .mode_q    (mode_q),
    .flag      (flag)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
    localparam int CLK_PERIOD = 10;

    logic        clk, rst_n;
    logic        wr_en, wr_wide, wr_sel, rd_en, rd_sel;
    logic [15:0] wr_data;
    logic [7:0]  rd_data;
    logic        ovf_pulse, irq;

    keyed_wdt dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .ovf_pulse(ovf_pulse), .irq(irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0, mon_on = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model built from the requirements
    logic [11:0] m_pre;
    logic [7:0]  m_cnt;
    logic [2:0]  m_cks;
    logic        m_mode, m_en, m_flag, m_armed, m_pulse;
    logic        t_tick, t_kc, t_ks, t_ovf;

    function automatic logic [11:0] tap_mask(input logic [2:0] c);
        case (c)
            3'd0: return 12'h000;
            3'd1: return 12'h003;
            3'd2: return 12'h00F;
            3'd3: return 12'h01F;
            3'd4: return 12'h03F;
            3'd5: return 12'h0FF;
            3'd6: return 12'h3FF;
            default: return 12'hFFF;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre <= '0; m_cnt <= '0; m_cks <= '0; m_mode <= 0; m_en <= 0;
            m_flag <= 0; m_armed <= 0; m_pulse <= 0;
        end else begin
            t_tick = m_en && ((m_pre & tap_mask(m_cks)) == tap_mask(m_cks));
            t_kc   = wr_en && wr_wide && !wr_sel && wr_data[15:8] == 8'h5A;
            t_ks   = wr_en && wr_wide &&  wr_sel && wr_data[15:8] == 8'hA5;
            t_ovf  = t_tick && m_cnt == 8'hFF && !t_kc;
            m_pre  <= m_pre + 1'b1;
            if (t_kc)        m_cnt <= wr_data[7:0];
            else if (t_tick) m_cnt <= m_cnt + 1'b1;
            m_pulse <= t_ovf && m_mode;
            if (t_ovf && !m_mode) begin
                m_flag <= 1; m_armed <= 0;
            end else if (m_armed && t_ks && !wr_data[7]) begin
                m_flag <= 0; m_armed <= 0;
            end else if (m_flag && rd_en && rd_sel) begin
                m_armed <= 1;
            end
            if (t_ks) begin
                m_mode <= wr_data[6]; m_en <= wr_data[5]; m_cks <= wr_data[2:0];
            end
        end
    end

    // continuous comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && mon_on && !done) begin
            chk("R7 ovf_pulse", ovf_pulse, m_pulse);
            chk("R8 irq", irq, m_flag && !m_mode);
            if (rd_sel) chk("R9 control read", rd_data, {m_flag, m_mode, m_en, 2'b11, m_cks});
            else        chk("R1 counter read", rd_data, m_cnt);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input logic we, input logic wide, input logic sel, input logic [15:0] d,
                        input logic re, input logic rs);
        wr_en = we; wr_wide = wide; wr_sel = sel; wr_data = d; rd_en = re; rd_sel = rs;
        @(posedge clk); #1;
    endtask

    task automatic idle(input logic rs);
        step(0, 0, 0, 16'h0000, 0, rs);
    endtask

    initial begin
        int n;
        logic [7:0] b;
        void'($urandom(32'd4242));
        rst_n = 0; wr_en = 0; wr_wide = 0; wr_sel = 0; wr_data = '0; rd_en = 0; rd_sel = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R10 counter after reset", rd_data, 8'h00);
        chk("R10 irq after reset", irq, 1'b0);
        chk("R10 ovf_pulse after reset", ovf_pulse, 1'b0);
        idle(1);
        @(negedge clk);
        chk("R10 control after reset", rd_data, 8'h18);
        mon_on = 1;

        // R8: interval overflow
        step(1, 1, 1, 16'hA520, 0, 1);
        step(1, 1, 0, 16'h5AFD, 0, 1);
        n = 0;
        while (!irq && n < 10) begin idle(1); n++; end
        @(negedge clk);
        chk("R8 irq after interval overflow", irq, 1'b1);
        chk("R8 flag bit set", rd_data[7], 1'b1);

        // R6: clear without prior read has no effect
        step(1, 1, 1, 16'hA520, 0, 1);
        @(negedge clk);
        chk("R6 unread flag kept", rd_data[7], 1'b1);
        step(0, 0, 0, 16'h0000, 1, 1);
        step(1, 1, 1, 16'hA520, 0, 1);
        @(negedge clk);
        chk("R6 flag cleared after read", rd_data[7], 1'b0);
        chk("R6 irq cleared", irq, 1'b0);
        step(1, 1, 1, 16'hA5A0, 0, 1);
        @(negedge clk);
        chk("R6 writing 1 leaves flag clear", rd_data[7], 1'b0);

        // R11: overflow coincides with an armed clear
        step(1, 1, 0, 16'h5AFD, 0, 1);
        n = 0;
        while (!irq && n < 10) begin idle(1); n++; end
        step(0, 0, 0, 16'h0000, 1, 1);
        step(1, 1, 0, 16'h5AFE, 0, 1);
        idle(1);
        step(1, 1, 1, 16'hA520, 0, 1);
        @(negedge clk);
        chk("R11 set wins over clear", rd_data[7], 1'b1);

        // R7: watchdog overflow
        step(1, 1, 1, 16'hA560, 0, 0);
        step(1, 1, 0, 16'h5AFF, 0, 0);
        @(negedge clk);
        chk("R3 load wins, no overflow", ovf_pulse, 1'b0);
        idle(0);
        @(negedge clk);
        chk("R7 pulse on overflow", ovf_pulse, 1'b1);
        chk("R7 counter wrapped", rd_data, 8'h00);
        chk("R8 irq low in watchdog mode", irq, 1'b0);
        idle(0);
        @(negedge clk);
        chk("R7 pulse one cycle", ovf_pulse, 1'b0);

        // R5: rejected writes
        step(1, 1, 1, 16'hA500, 0, 0);
        step(1, 1, 0, 16'h5A33, 0, 0);
        step(1, 1, 0, 16'h5B77, 0, 0);
        step(1, 0, 0, 16'h5A77, 0, 0);
        step(1, 1, 0, 16'hA577, 0, 0);
        step(1, 1, 1, 16'h5A65, 0, 0);
        step(1, 0, 1, 16'hA565, 0, 0);
        @(negedge clk);
        chk("R5 counter untouched", rd_data, 8'h33);
        idle(1);
        @(negedge clk);
        chk("R5 control untouched", rd_data, 8'h98);

        // R9: reserved bits
        step(1, 1, 1, 16'hA5FF, 0, 1);
        @(negedge clk);
        chk("R9 all-ones write", rd_data, 8'hFF);
        step(1, 1, 1, 16'hA500, 0, 1);
        @(negedge clk);
        chk("R9 all-zero write", rd_data, 8'h98);

        // R1: hold while disabled
        repeat (20) idle(0);
        @(negedge clk);
        chk("R1 held while disabled", rd_data, 8'h33);

        // R2: slowest tap
        step(1, 1, 0, 16'h5AFF, 0, 0);
        step(1, 1, 1, 16'hA567, 0, 0);
        n = 0;
        while (!ovf_pulse && n < 5000) begin idle(0); n++; end
        chk("R2 slowest tap within 4096 cycles", (n <= 4096), 1'b1);
        chk("R4 watchdog fired at slowest tap", ovf_pulse, 1'b1);

        // random mix, checked continuously by the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom % 100;
            b = 8'($urandom);
            if (r < 6) begin
                if ($urandom % 2) b = b | 8'hF8;
                step(1, 1, 0, {8'h5A, b}, $urandom % 3 == 0, $urandom % 2);
            end else if (r < 11) begin
                b[2:0] = 3'($urandom % 3);
                if ($urandom % 4 != 0) b[5] = 1'b1;
                step(1, 1, 1, {8'hA5, b}, $urandom % 3 == 0, $urandom % 2);
            end else if (r < 15) begin
                step(1, $urandom % 2, $urandom % 2, {8'($urandom | 1), b}, 0, $urandom % 2);
            end else begin
                step(0, 0, 0, 16'h0000, $urandom % 3 == 0, $urandom % 2);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule